// File: doc/BRIEF.md
# Vectoring CORDIC Magnitude and Phase Unit

This block turns a signed Cartesian pair into polar form. A start strobe captures x and y, and the unit then performs one shift-and-add micro-rotation per clock. Each step turns the vector toward the positive x axis and records the turned angle in an accumulator. When the last step is done, the unit raises a one-cycle done flag. It then presents the x register as a magnitude that carries the CORDIC gain (about 1.647 for 16 steps), and the accumulator as the phase.

A vector in the left half-plane first gets a quarter-turn with no growth, which brings it into the right half-plane. This gives the unit the full circle of input angles. The phase is a binary angle, where the full signed range covers one turn. A host that needs the true magnitude scales the result by the reciprocal of the gain outside the block.

The controller is a three-state machine. ST_IDLE waits for the strobe and, on accepting it, loads the pre-rotated vector (transition IDLE to ROTATE). ST_ROTATE performs one micro-rotation per cycle and stays in place until the step counter reaches ITERS-1 (transition ROTATE to FINISH, with the result registers loaded on that edge). ST_FINISH drives done for one cycle and always returns to ST_IDLE (transition FINISH to IDLE).

Top module: `cordic_vec_unit`

## Requirements
- R1: After reset, done_o is 0 and both mag_o and ang_o read 0.
- R2: If start_i is high at a rising edge while the unit is idle, done_o rises ITERS rising edges later and stays high for exactly one cycle.
- R3: For an input with x_i >= 0, mag_o at done equals G·sqrt(x²+y²) within ITERS+4 LSB. Here G = product over i=0..ITERS-1 of sqrt(1+2^-2i).
- R4: ang_o is a signed AW-bit binary angle, where a value of 2^(AW-1) stands for π radians and counterclockwise from the +x axis is positive. For x_i >= 0 it equals atan2(y,x) within the bench tolerance.
- R5: For an input with x_i < 0, a pre-rotation by ±π/2 first moves the vector into the right half-plane, so magnitude and phase are correct over the whole circle. An input on the negative x axis yields ±π, which is code 0x8000 for AW=16.
- R6: The zero vector (0, 0) yields mag_o = 0 and ang_o = 0.
- R7: While a computation is in progress, start_i and the data inputs are ignored, and the result belongs to the vector captured at the accepting edge.
- R8: mag_o and ang_o change only on the edge that raises done_o. Between results they hold their values, whatever the inputs do.
- R9: Inputs at the ends of the 16-bit range, for example (-32768, -32768), produce no overflow: mag_o stays correct and positive, thanks to two guard bits in the internal registers.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low reset, asynchronous assert |
| start_i | input | 1 | Starts a conversion when the unit is idle |
| x_i | input | DW | Signed x component |
| y_i | input | DW | Signed y component |
| done_o | output | 1 | One-cycle pulse when a result is ready |
| mag_o | output | DW+2 | Gain-scaled magnitude, unsigned |
| ang_o | output | AW | Signed binary phase, 2^(AW-1) = π |

## Verification
The hardest case to reach from the ports is a second start strobe that arrives while the micro-rotations are still running. A correct unit shows nothing at its outputs in that case. The stimulus therefore starts one vector and, a few cycles later, drives a strobe with a very different vector. It then compares the delivered result against the first vector's expected values, and confirms that done appears only once at the expected latency. The left-half-plane quarter-turn and the ±π wrap are reached through vectors that lie exactly on the negative x axis, and in all four quadrants.

// File: rtl/cordic_vec_pkg.sv
package cordic_vec_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ROTATE = 2'd1,
        ST_FINISH = 2'd2
    } vec_state_e;

    // atan(2^-idx) as a binary angle where 2^(aw-1) = pi, rounded.
    // Series evaluated on a 2^40 fixed-point scale; idx 0 is exactly pi/4.
    function automatic longint atan_bam(input int idx, input int aw);
        longint unit_s;
        longint pi_s;
        longint acc;
        longint term;
        unit_s = 64'sd1 << 40;
        pi_s   = 64'sd3454217652358;
        acc    = 0;
        if (idx == 0) begin
            return 64'sd1 <<< (aw - 3);
        end
        for (int k = 1; k <= 61; k += 2) begin
            if (k * idx <= 40) begin
                term = (unit_s >>> (k * idx)) / longint'(k);
                if (((k >> 1) & 1) == 1) acc = acc - term;
                else                     acc = acc + term;
            end
        end
        return (acc * (64'sd1 <<< (aw - 1)) + pi_s / 2) / pi_s;
    endfunction

endpackage

// File: rtl/cordic_vec_prerot.sv
module cordic_vec_prerot #(
    parameter int DW = 16,
    parameter int XW = 18,
    parameter int AW = 16
) (
    input  logic signed [DW-1:0] x_i,
    input  logic signed [DW-1:0] y_i,
    output logic signed [XW-1:0] x_o,
    output logic signed [XW-1:0] y_o,
    output logic signed [AW-1:0] z_o
);
    localparam logic signed [AW-1:0] QUARTER = AW'(1) <<< (AW - 2);

    logic signed [XW-1:0] xs;
    logic signed [XW-1:0] ys;

    assign xs = XW'(x_i);
    assign ys = XW'(y_i);

    always_comb begin
        if (x_i < 0) begin
            if (y_i < 0) begin
                // turn counterclockwise by a quarter, remember -pi/2
                x_o = -ys;
                y_o = xs;
                z_o = -QUARTER;
            end else begin
                // turn clockwise by a quarter, remember +pi/2
                x_o = ys;
                y_o = -xs;
                z_o = QUARTER;
            end
        end else begin
            x_o = xs;
            y_o = ys;
            z_o = '0;
        end
    end
endmodule

// File: rtl/cordic_vec_microrot.sv
module cordic_vec_microrot #(
    parameter int XW = 18,
    parameter int AW = 16,
    parameter int CW = 4
) (
    input  logic signed [XW-1:0] x_i,
    input  logic signed [XW-1:0] y_i,
    input  logic signed [AW-1:0] z_i,
    input  logic        [CW-1:0] shift_i,
    input  logic signed [AW-1:0] atan_i,
    output logic signed [XW-1:0] x_o,
    output logic signed [XW-1:0] y_o,
    output logic signed [AW-1:0] z_o
);
    logic signed [XW-1:0] x_sh;
    logic signed [XW-1:0] y_sh;

    assign x_sh = x_i >>> shift_i;
    assign y_sh = y_i >>> shift_i;

    always_comb begin
        if (y_i < 0) begin
            // residual below the axis: turn counterclockwise
            x_o = x_i - y_sh;
            y_o = y_i + x_sh;
            z_o = z_i - atan_i;
        end else begin
            x_o = x_i + y_sh;
            y_o = y_i - x_sh;
            z_o = z_i + atan_i;
        end
    end
endmodule

// File: rtl/cordic_vec_atan_rom.sv
module cordic_vec_atan_rom
    import cordic_vec_pkg::*;
#(
    parameter int AW    = 16,
    parameter int ITERS = 16,
    parameter int CW    = 4
) (
    input  logic        [CW-1:0] idx_i,
    output logic signed [AW-1:0] atan_o
);
    logic signed [AW-1:0] tab [ITERS];

    for (genvar g = 0; g < ITERS; g++) begin : g_entry
        assign tab[g] = AW'(atan_bam(g, AW));
    end

    assign atan_o = tab[idx_i];
endmodule

// File: rtl/cordic_vec_unit.sv
module cordic_vec_unit
    import cordic_vec_pkg::*;
#(
    parameter int DW    = 16,
    parameter int AW    = 16,
    parameter int ITERS = 16
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 start_i,
    input  logic signed [DW-1:0] x_i,
    input  logic signed [DW-1:0] y_i,
    output logic                 done_o,
    output logic [DW+1:0]        mag_o,
    output logic signed [AW-1:0] ang_o
);
    localparam int XW = DW + 2;
    localparam int CW = (ITERS > 1) ? $clog2(ITERS) : 1;
    localparam logic [CW-1:0] LAST = CW'(ITERS - 1);

    vec_state_e st_q, st_d;

    logic signed [XW-1:0] x_q, y_q;
    logic signed [AW-1:0] z_q;
    logic        [CW-1:0] cnt_q;
    logic                 zero_q;
    logic        [XW-1:0] mag_q;
    logic signed [AW-1:0] ang_q;

    logic signed [XW-1:0] pre_x, pre_y, nxt_x, nxt_y;
    logic signed [AW-1:0] pre_z, nxt_z, atan_w;
    logic                 accept, last_step;

    assign accept    = (st_q == ST_IDLE) && start_i;
    assign last_step = (cnt_q == LAST);

    cordic_vec_prerot #(.DW(DW), .XW(XW), .AW(AW)) u_prerot (
        .x_i (x_i),
        .y_i (y_i),
        .x_o (pre_x),
        .y_o (pre_y),
        .z_o (pre_z)
    );

    cordic_vec_atan_rom #(.AW(AW), .ITERS(ITERS), .CW(CW)) u_rom (
        .idx_i  (cnt_q),
        .atan_o (atan_w)
    );

    cordic_vec_microrot #(.XW(XW), .AW(AW), .CW(CW)) u_step (
        .x_i     (x_q),
        .y_i     (y_q),
        .z_i     (z_q),
        .shift_i (cnt_q),
        .atan_i  (atan_w),
        .x_o     (nxt_x),
        .y_o     (nxt_y),
        .z_o     (nxt_z)
    );

    // next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:   if (start_i)   st_d = ST_ROTATE;
            ST_ROTATE: if (last_step) st_d = ST_FINISH;
            ST_FINISH:                st_d = ST_IDLE;
            default:                  st_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= ST_IDLE;
        else         st_q <= st_d;
    end

    // working registers
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            x_q    <= '0;
            y_q    <= '0;
            z_q    <= '0;
            cnt_q  <= '0;
            zero_q <= 1'b0;
        end else if (accept) begin
            x_q    <= pre_x;
            y_q    <= pre_y;
            z_q    <= pre_z;
            cnt_q  <= '0;
            zero_q <= (x_i == '0) && (y_i == '0);
        end else if (st_q == ST_ROTATE) begin
            x_q   <= nxt_x;
            y_q   <= nxt_y;
            z_q   <= nxt_z;
            cnt_q <= cnt_q + CW'(1);
        end
    end

    // result registers: loaded on the edge that enters ST_FINISH
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            mag_q <= '0;
            ang_q <= '0;
        end else if ((st_q == ST_ROTATE) && last_step) begin
            mag_q <= $unsigned(nxt_x);
            ang_q <= zero_q ? '0 : nxt_z;
        end
    end

    // output decode
    always_comb begin
        done_o = (st_q == ST_FINISH);
        mag_o  = mag_q;
        ang_o  = ang_q;
    end
endmodule

// File: rtl/cordic_vec_checker.sv
module cordic_vec_checker
    import cordic_vec_pkg::*;
#(
    parameter int DW    = 16,
    parameter int AW    = 16,
    parameter int ITERS = 16
) (
    input logic                 clk_i,
    input logic                 rst_ni,
    input logic                 start_i,
    input logic signed [DW-1:0] x_i,
    input logic signed [DW-1:0] y_i,
    input logic                 done_o,
    input logic [DW+1:0]        mag_o,
    input logic signed [AW-1:0] ang_o,
    input vec_state_e           st_q
);
    int   lat_q;
    logic zcap_q;
    logic past_ok_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            lat_q     <= 0;
            zcap_q    <= 1'b0;
            past_ok_q <= 1'b0;
        end else begin
            past_ok_q <= 1'b1;
            if (lat_q == 0 && start_i && st_q == ST_IDLE) begin
                lat_q  <= 1;
                zcap_q <= (x_i == '0) && (y_i == '0);
            end else if (done_o) begin
                lat_q <= 0;
            end else if (lat_q != 0) begin
                lat_q <= lat_q + 1;
            end
        end
    end

    assert_done_pulse_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);

    assert_done_latency_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> (lat_q == ITERS + 1));

    assert_busy_no_restart_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (lat_q != 0 && !done_o) |=> (st_q != ST_IDLE));

    assert_zero_vector_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_o && zcap_q) |-> (mag_o == '0 && ang_o == '0));

    assert_result_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (past_ok_q && !done_o) |-> ($stable(mag_o) && $stable(ang_o)));

    assert_no_overflow_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> !mag_o[DW+1]);
endmodule

bind cordic_vec_unit cordic_vec_checker #(.DW(DW), .AW(AW), .ITERS(ITERS)) u_chk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .x_i     (x_i),
    .y_i     (y_i),
    .done_o  (done_o),
    .mag_o   (mag_o),
    .ang_o   (ang_o),
    .st_q    (st_q)
);

// File: tb/tb_cordic_vec_unit.sv
module tb_cordic_vec_unit;
    localparam int DW = 16;
    localparam int AW = 16;
    localparam int ITERS = 16;
    localparam real PI = 3.14159265358979;
    localparam int NV = 12;

    localparam logic signed [DW-1:0] VX [NV] = '{
        16'sd20000, 16'sd0, 16'sd15000, 16'sd15000, 16'sd12345, 16'sd1000,
        16'sd32767, -16'sd20000, -16'sd15000, -16'sd15000, -16'sd30000, -16'sd32768};
    localparam logic signed [DW-1:0] VY [NV] = '{
        16'sd0, 16'sd20000, 16'sd15000, -16'sd15000, -16'sd23456, 16'sd30000,
        16'sd32767, 16'sd0, 16'sd15000, -16'sd15000, 16'sd5000, -16'sd32768};

    logic clk = 1'b0;
    logic rst_ni = 1'b0;
    logic start_i = 1'b0;
    logic signed [DW-1:0] x_i = '0;
    logic signed [DW-1:0] y_i = '0;
    logic done_o;
    logic [DW+1:0] mag_o;
    logic signed [AW-1:0] ang_o;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    cordic_vec_unit #(.DW(DW), .AW(AW), .ITERS(ITERS)) dut (
        .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i),
        .x_i(x_i), .y_i(y_i), .done_o(done_o), .mag_o(mag_o), .ang_o(ang_o));

    function automatic real gain();
        real g = 1.0;
        for (int i = 0; i < ITERS; i++) g = g * $sqrt(1.0 + 2.0 ** (-2.0 * i));
        return g;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic expect_vec(input logic signed [DW-1:0] x, input logic signed [DW-1:0] y,
                              input string req);
        real r, em, ea;
        longint emi, eai, dd;
        int tol_a;
        r   = $sqrt(real'(x) * real'(x) + real'(y) * real'(y));
        em  = gain() * r;
        emi = longint'(em);
        ea  = $atan2(real'(y), real'(x)) * (2.0 ** (AW - 1)) / PI;
        eai = longint'(ea);
        tol_a = 16 + int'(3.0 * ITERS * (2.0 ** (AW - 1)) / (PI * gain() * r));
        check((longint'(mag_o) - emi <= ITERS + 4) && (emi - longint'(mag_o) <= ITERS + 4),
              req, "magnitude", longint'(mag_o), emi);
        dd = (longint'(ang_o) - eai) % 65536;
        if (dd > 32767) dd -= 65536;
        if (dd < -32768) dd += 65536;
        check((dd <= tol_a) && (dd >= -tol_a), req, "angle", longint'(ang_o), eai);
    endtask

    task automatic run_vec(input logic signed [DW-1:0] x, input logic signed [DW-1:0] y,
                           output int lat);
        @(negedge clk);
        x_i = x; y_i = y; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        lat = 0;
        while (!done_o && lat < 1000) begin
            @(negedge clk);
            lat++;
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : main
        int lat;
        logic [DW+1:0] hold_m;
        logic signed [AW-1:0] hold_a;

        repeat (3) @(negedge clk);
        rst_ni = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(done_o == 1'b0, "R1", "done after reset", longint'(done_o), 0);
        check(mag_o == '0, "R1", "mag after reset", longint'(mag_o), 0);
        check(ang_o == '0, "R1", "ang after reset", longint'(ang_o), 0);

        // table walk: R3/R4 right half-plane, R5 left half-plane, R9 extremes
        for (int v = 0; v < NV; v++) begin
            run_vec(VX[v], VY[v], lat);
            if (v == 0) begin
                check(lat == ITERS, "R2", "latency in edges", lat, ITERS);
            end
            if (VX[v] == -16'sd32768 || VX[v] == 16'sd32767) expect_vec(VX[v], VY[v], "R9");
            else if (VX[v] < 0) expect_vec(VX[v], VY[v], "R5");
            else expect_vec(VX[v], VY[v], "R3/R4");
            @(negedge clk);
            if (v == 0) check(done_o == 1'b0, "R2", "done width", longint'(done_o), 0);
        end

        // R5: negative x axis gives code 0x8000 (pi)
        run_vec(-16'sd20000, 16'sd0, lat);
        check(ang_o == 16'sh8000, "R5", "angle on negative axis", longint'($unsigned(ang_o)), 32768);

        // R6 zero vector
        run_vec(16'sd0, 16'sd0, lat);
        check(mag_o == '0, "R6", "zero magnitude", longint'(mag_o), 0);
        check(ang_o == '0, "R6", "zero angle", longint'(ang_o), 0);

        // R7: a strobe while busy is ignored
        @(negedge clk);
        x_i = 16'sd10000; y_i = 16'sd17320; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        repeat (3) @(negedge clk);
        x_i = -16'sd25000; y_i = -16'sd4000; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        lat = 4;
        while (!done_o && lat < 1000) begin
            @(negedge clk);
            lat++;
        end
        check(lat == ITERS, "R7", "single done at first latency", lat, ITERS);
        expect_vec(16'sd10000, 16'sd17320, "R7");
        @(negedge clk);
        check(done_o == 1'b0, "R7", "no second done", longint'(done_o), 0);

        // R8: outputs hold while idle with changing inputs
        hold_m = mag_o;
        hold_a = ang_o;
        for (int k = 0; k < 6; k++) begin
            x_i = DW'(k * 3001 - 9000);
            y_i = DW'(7000 - k * 2500);
            @(negedge clk);
        end
        check(mag_o == hold_m, "R8", "mag held", longint'(mag_o), longint'(hold_m));
        check(ang_o == hold_a, "R8", "ang held", longint'(ang_o), longint'(hold_a));

        finished = 1'b1;
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule